// File: doc/BRIEF.md
# PHY Tuning Parameter Sequencer

After reset, a PHY usually needs a few trim fields adjusted before the link can run. This block does that job without any software. It masters a simple 32-bit register bus that has a valid/ready handshake. It reaches the PHY's internal 8-bit registers through an indirect port. That port has two registers: a command register at byte offset 0x0, which is only written, and a data register at byte offset 0x4, which is only read.

When `start` is pulsed, the block walks a fixed table of up to seven entries. Each entry names a PHY register, a bit field in it, and a value. For each entry the block reads the current byte through the port, merges the value into the field, and writes the byte back with a strobed command. It then reads the register once more, after the write, before it moves on. After every command write, the PHY needs two throw-away reads of the data register, and the block always issues them. A legacy input makes a start finish at once with no bus traffic.

Top module: `phy_tune_seq`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `busy`, `done` and `bus_valid` are all low.
- R2: A command write goes to offset 0x0. Its word carries the strobe in bit 0, the PHY register number in bits [5:1], the 8-bit data in bits [13:6], and zero in all higher bits. Every read goes to offset 0x4. Only `bus_rdata[7:0]` is used.
- R3: Every command write is followed by at least two reads of the data register before the next command write.
- R4: Each entry begins with a query. This is a command write with data 1, strobe 0 and the entry's register number. Two reads follow, and the third read after the query supplies the old byte.
- R5: The new byte is the old byte with bits msb..lsb cleared, ORed with (value << lsb) limited to those bits.
- R6: The new byte is written with three commands that share the same data and register number. Their strobe bits are 0, then 1, then 0. Each command is followed by two reads.
- R7: After the write, the entry ends with a check-back read: a query command, two reads, and one more read. The next entry starts only after that.
- R8: The default table is processed in this order. Each item is (register, msb:lsb, value): (7, 3:0, 10), (8, 3:0, 3), (9, 3:0, 5), (11, 3:0, 9), (13, 6:5, 2), (27, 2:0, 7), (28, 1:0, 1). That gives 17 bus transfers per entry and no others.
- R9: If `legacy_mode` is high when a start is taken, the block makes no bus transfer and raises `done` in the next cycle.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` stay unchanged.
- R11: Once a start is taken, `busy` is high and `done` is low from the next cycle. `done` rises and `busy` falls in the cycle after the last transfer completes. A start seen while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a tuning pass when idle |
| legacy_mode | input | 1 | Skip the parameter pass |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Pass finished; held until the next start |
| bus_valid | output | 1 | Transfer request |
| bus_write | output | 1 | 1 = write to command register, 0 = read data register |
| bus_addr | output | BUS_AW | Byte offset within the port |
| bus_wdata | output | BUS_DW | Command word |
| bus_ready | input | 1 | Transfer accepted this cycle |
| bus_rdata | input | BUS_DW | Read data, valid when a read is accepted |

## Verification
Two events can collide in the same cycle. One is the completion of the final transfer of the pass. The other is a new `start` request. The bench holds `start` high through a whole pass and lowers it only after that final handshake edge. The block must not restart at that edge, so `done` must be high with the bus idle afterwards. A second overlap comes from back-to-back handshakes. The captured read byte feeds the very next command word in the same edge. The bench therefore runs passes both with `bus_ready` always high and with random stalls, and compares every request against a queue built from R2 to R8.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;

  localparam int PHY_BYTE_W      = 8;
  localparam int PHY_REG_W       = 5;
  localparam int FIELD_POS_W     = 3;
  localparam int MAX_ENTRIES     = 7;
  localparam int CMD_STROBE_BIT  = 0;
  localparam int CMD_REG_LSB     = 1;
  localparam int CMD_DATA_LSB    = CMD_REG_LSB + PHY_REG_W;
  localparam int CMD_W           = CMD_DATA_LSB + PHY_BYTE_W;
  localparam int STEPS_PER_ENTRY = 17;
  localparam int STEP_W          = $clog2(STEPS_PER_ENTRY);
  localparam int STEP_CAPTURE    = 3;

  typedef struct packed {
    logic [PHY_REG_W-1:0]   regno;
    logic [FIELD_POS_W-1:0] msb;
    logic [FIELD_POS_W-1:0] lsb;
    logic [PHY_BYTE_W-1:0]  value;
  } tune_entry_t;

  typedef enum logic [1:0] {
    OP_READ_DATA,
    OP_CMD_QUERY,
    OP_CMD_SET,
    OP_CMD_STROBE
  } step_op_t;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_RUN
  } seq_state_t;

  function automatic tune_entry_t table_entry(input logic [2:0] idx);
    tune_entry_t e;
    case (idx)
      3'd0:    e = '{regno: 5'd7,  msb: 3'd3, lsb: 3'd0, value: 8'd10};
      3'd1:    e = '{regno: 5'd8,  msb: 3'd3, lsb: 3'd0, value: 8'd3};
      3'd2:    e = '{regno: 5'd9,  msb: 3'd3, lsb: 3'd0, value: 8'd5};
      3'd3:    e = '{regno: 5'd11, msb: 3'd3, lsb: 3'd0, value: 8'd9};
      3'd4:    e = '{regno: 5'd13, msb: 3'd6, lsb: 3'd5, value: 8'd2};
      3'd5:    e = '{regno: 5'd27, msb: 3'd2, lsb: 3'd0, value: 8'd7};
      3'd6:    e = '{regno: 5'd28, msb: 3'd1, lsb: 3'd0, value: 8'd1};
      default: e = '0;
    endcase
    return e;
  endfunction

  // Step schedule within one entry: query, 2 reads, capture read,
  // set/strobe/set each with 2 reads, query, 2 reads, check-back read.
  function automatic step_op_t step_op(input logic [STEP_W-1:0] s);
    step_op_t op;
    case (s)
      5'd0, 5'd13: op = OP_CMD_QUERY;
      5'd4, 5'd10: op = OP_CMD_SET;
      5'd7:        op = OP_CMD_STROBE;
      default:     op = OP_READ_DATA;
    endcase
    return op;
  endfunction

  function automatic logic [CMD_W-1:0] cmd_word(input logic [PHY_BYTE_W-1:0] data,
                                                input logic [PHY_REG_W-1:0]  regno,
                                                input logic                  strobe);
    return {data, regno, strobe};
  endfunction

endpackage

// File: rtl/phy_tune_table.sv
module phy_tune_table
  import phy_tune_pkg::*;
#(
  parameter int NUM_ENTRIES = 7,
  parameter int IDX_W       = 3
) (
  input  logic [IDX_W-1:0] idx,
  output tune_entry_t      entry
);

  localparam int ROM_DEPTH = 2 ** IDX_W;

  tune_entry_t rom [ROM_DEPTH];

  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
    if (g < NUM_ENTRIES && g < MAX_ENTRIES) begin : g_used
      assign rom[g] = table_entry(3'(g));
    end else begin : g_blank
      assign rom[g] = '0;
    end
  end

  assign entry = rom[idx];

endmodule

// File: rtl/phy_tune_merge.sv
module phy_tune_merge
  import phy_tune_pkg::*;
(
  input  tune_entry_t           entry,
  input  logic [PHY_BYTE_W-1:0] old_byte,
  output logic [PHY_BYTE_W-1:0] new_byte
);

  logic [PHY_BYTE_W-1:0] field_mask;
  logic [PHY_BYTE_W-1:0] shifted;

  for (genvar b = 0; b < PHY_BYTE_W; b++) begin : g_mask
    assign field_mask[b] = (FIELD_POS_W'(b) >= entry.lsb) && (FIELD_POS_W'(b) <= entry.msb);
  end

  assign shifted  = entry.value << entry.lsb;
  assign new_byte = (old_byte & ~field_mask) | (shifted & field_mask);

endmodule

// File: rtl/phy_tune_seq.sv
module phy_tune_seq
  import phy_tune_pkg::*;
#(
  parameter int                NUM_ENTRIES = 7,
  parameter int                BUS_AW      = 4,
  parameter int                BUS_DW      = 32,
  parameter logic [BUS_AW-1:0] CMD_OFFSET  = BUS_AW'(0),
  parameter logic [BUS_AW-1:0] DATA_OFFSET = BUS_AW'(4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              legacy_mode,
  output logic              busy,
  output logic              done,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [BUS_DW-1:0] bus_rdata
);

  localparam int                IDX_W     = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS_PER_ENTRY - 1);
  localparam logic [STEP_W-1:0] STEP_CAP  = STEP_W'(STEP_CAPTURE);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(NUM_ENTRIES - 1);

  seq_state_t            state_q;
  logic [IDX_W-1:0]      idx_q, nxt_idx;
  logic [STEP_W-1:0]     step_q, nxt_step;
  logic [PHY_BYTE_W-1:0] old_q, old_sel, merged;
  tune_entry_t           nxt_entry;
  step_op_t              nxt_op;
  logic [CMD_W-1:0]      nxt_cmd;
  logic                  xfer, launch, skip, last_xfer;
  logic                  unused_rdata_hi;

  assign unused_rdata_hi = ^bus_rdata[BUS_DW-1:PHY_BYTE_W];

  assign xfer      = bus_valid && bus_ready;
  assign launch    = (state_q == SEQ_IDLE) && start && !legacy_mode;
  assign skip      = (state_q == SEQ_IDLE) && start && legacy_mode;
  assign last_xfer = xfer && (step_q == STEP_LAST) && (idx_q == IDX_LAST);

  always_comb begin
    if (state_q == SEQ_IDLE) begin
      nxt_step = '0;
      nxt_idx  = '0;
    end else if (step_q == STEP_LAST) begin
      nxt_step = '0;
      nxt_idx  = idx_q + IDX_W'(1);
    end else begin
      nxt_step = step_q + STEP_W'(1);
      nxt_idx  = idx_q;
    end
  end

  // The byte captured by the read at STEP_CAPTURE feeds the very next command.
  assign old_sel = ((state_q == SEQ_RUN) && (step_q == STEP_CAP)) ?
                   bus_rdata[PHY_BYTE_W-1:0] : old_q;

  phy_tune_table #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .IDX_W       (IDX_W)
  ) table_i (
    .idx   (nxt_idx),
    .entry (nxt_entry)
  );

  phy_tune_merge merge_i (
    .entry    (nxt_entry),
    .old_byte (old_sel),
    .new_byte (merged)
  );

  assign nxt_op  = step_op(nxt_step);
  assign nxt_cmd = (nxt_op == OP_CMD_QUERY) ?
                   cmd_word(PHY_BYTE_W'(1), nxt_entry.regno, 1'b0) :
                   cmd_word(merged, nxt_entry.regno, nxt_op == OP_CMD_STROBE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_IDLE;
      idx_q     <= '0;
      step_q    <= '0;
      old_q     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      if (skip) begin
        done <= 1'b1;
      end
      if (xfer && (step_q == STEP_CAP)) begin
        old_q <= bus_rdata[PHY_BYTE_W-1:0];
      end
      if (launch || (xfer && !last_xfer)) begin
        state_q   <= SEQ_RUN;
        busy      <= 1'b1;
        done      <= 1'b0;
        step_q    <= nxt_step;
        idx_q     <= nxt_idx;
        bus_valid <= 1'b1;
        bus_write <= (nxt_op != OP_READ_DATA);
        bus_addr  <= (nxt_op != OP_READ_DATA) ? CMD_OFFSET : DATA_OFFSET;
        bus_wdata <= (nxt_op != OP_READ_DATA) ? BUS_DW'(nxt_cmd) : '0;
      end else if (last_xfer) begin
        state_q   <= SEQ_IDLE;
        busy      <= 1'b0;
        done      <= 1'b1;
        bus_valid <= 1'b0;
        bus_write <= 1'b0;
        bus_addr  <= '0;
        bus_wdata <= '0;
      end
    end
  end

  // Observation state for the protocol checks below.
  logic [1:0]       chk_reads;
  logic             chk_seen_cmd;
  logic [CMD_W-1:0] chk_last_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_reads    <= '0;
      chk_seen_cmd <= 1'b0;
      chk_last_cmd <= '0;
    end else if (xfer) begin
      if (bus_write) begin
        chk_reads    <= '0;
        chk_seen_cmd <= 1'b1;
        chk_last_cmd <= bus_wdata[CMD_W-1:0];
      end else if (chk_reads != 2'd3) begin
        chk_reads <= chk_reads + 2'd1;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_write) && $stable(bus_addr)
                                && $stable(bus_wdata)); // R10

  AST_CMD_LAYOUT: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_write |-> bus_addr == CMD_OFFSET
                               && bus_wdata[BUS_DW-1:CMD_W] == '0); // R2

  AST_READ_OFFSET: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_write |-> bus_addr == DATA_OFFSET); // R2

  AST_TWO_READS: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_write && chk_seen_cmd |-> chk_reads >= 2'd2); // R3

  AST_STROBE_AFTER_SET: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_write && bus_wdata[CMD_STROBE_BIT] |->
      chk_seen_cmd && chk_last_cmd == (bus_wdata[CMD_W-1:0] & ~CMD_W'(1))); // R6

  AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_write && chk_last_cmd[CMD_STROBE_BIT] |->
      !bus_wdata[CMD_STROBE_BIT]
      && bus_wdata[CMD_W-1:1] == chk_last_cmd[CMD_W-1:1]); // R6

  AST_LEGACY_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy && start && legacy_mode |=> done && !busy && !bus_valid); // R9

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R11

  AST_VALID_IN_PASS: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> busy); // R11

  AST_FINISH: assert property (@(posedge clk) disable iff (rst)
    last_xfer |=> done && !busy && !bus_valid); // R11

endmodule

// File: tb/phy_tune_seq_tb_top.sv
module phy_tune_seq_tb_top;

  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NE = 7;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } xact_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          legacy_mode = 1'b0;
  logic          busy, done;
  logic          bus_valid, bus_write;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_ready = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  int     vectors = 0;
  int     miscompares = 0;
  int     cycles = 0;
  bit     stall_mode = 1'b0;
  bit     finished = 1'b0;
  xact_t  exp_q[$];
  string  tag_q[$];
  logic [7:0] phy_reg [32];
  logic [7:0] exp_final [32];
  logic [4:0] cmd_sel = '0;

  // R8 table
  int t_reg [NE] = '{7, 8, 9, 11, 13, 27, 28};
  int t_msb [NE] = '{3, 3, 3, 3, 6, 2, 1};
  int t_lsb [NE] = '{0, 0, 0, 0, 5, 0, 0};
  int t_val [NE] = '{10, 3, 5, 9, 2, 7, 1};

  always #2 clk = ~clk;

  phy_tune_seq #(.NUM_ENTRIES(NE), .BUS_AW(AW), .BUS_DW(DW)) dut_i (
    .clk (clk), .rst (rst), .start (start), .legacy_mode (legacy_mode),
    .busy (busy), .done (done),
    .bus_valid (bus_valid), .bus_write (bus_write), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_ready (bus_ready), .bus_rdata (bus_rdata)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] cmd(input int data, input int regno, input int strobe);
    return DW'(((data & 255) << 6) | ((regno & 31) << 1) | (strobe & 1));
  endfunction

  task automatic push(input bit wr, input logic [DW-1:0] data, input string tag);
    exp_q.push_back('{wr: wr, addr: wr ? AW'(0) : AW'(4), data: wr ? data : '0});
    tag_q.push_back(tag);
  endtask

  task automatic build_expected();
    for (int e = 0; e < NE; e++) begin
      int mask = 0;
      int nb;
      for (int b = t_lsb[e]; b <= t_msb[e]; b++) mask |= (1 << b);
      nb = (int'(phy_reg[t_reg[e]]) & ~mask & 255) | ((t_val[e] << t_lsb[e]) & mask);
      exp_final[t_reg[e]] = 8'(nb);
      push(1, cmd(1, t_reg[e], 0), "R4");
      push(0, '0, "R3"); push(0, '0, "R3"); push(0, '0, "R4");
      push(1, cmd(nb, t_reg[e], 0), "R5");
      push(0, '0, "R3"); push(0, '0, "R3");
      push(1, cmd(nb, t_reg[e], 1), "R6");
      push(0, '0, "R3"); push(0, '0, "R3");
      push(1, cmd(nb, t_reg[e], 0), "R6");
      push(0, '0, "R3"); push(0, '0, "R3");
      push(1, cmd(1, t_reg[e], 0), "R7");
      push(0, '0, "R3"); push(0, '0, "R3"); push(0, '0, "R7");
    end
  endtask

  // Bus slave and per-clock comparison against the expected queue.
  always @(negedge clk) begin
    if (rst || finished) begin
      bus_ready = 1'b0;
      bus_rdata = '0;
    end else begin
      logic rdy;
      logic [DW-1:0] rd;
      if (bus_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "transfer outside expected sequence", bus_wdata, 0);
        end else begin
          check(bus_write === exp_q[0].wr && bus_addr === exp_q[0].addr, tag_q[0],
                "transfer kind/offset", {bus_write, bus_addr}, {exp_q[0].wr, exp_q[0].addr});
          if (exp_q[0].wr)
            check(bus_wdata === exp_q[0].data, tag_q[0], "command word (R2)",
                  bus_wdata, exp_q[0].data);
        end
      end
      rdy = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
      rd = $urandom();              // upper bits are noise (R2)
      rd[7:0] = phy_reg[cmd_sel];
      bus_ready = rdy;
      bus_rdata = rd;
      if (bus_valid && rdy && exp_q.size() > 0) begin
        if (bus_write) begin
          cmd_sel = bus_wdata[5:1];
          if (bus_wdata[0]) phy_reg[bus_wdata[5:1]] = bus_wdata[13:6];
        end
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic run_pass(input bit stall, input bit hold_start);
    build_expected();
    stall_mode = stall;
    start = 1'b1;
    @(negedge clk);
    if (!hold_start) start = 1'b0;
    check(busy === 1'b1 && done === 1'b0, "R11", "busy after start",
          {busy, done}, 2'b10);
    check(bus_valid === 1'b1, "R4", "first request issued", bus_valid, 1);
    wait (exp_q.size() == 0);
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1 && busy === 1'b0 && bus_valid === 1'b0, "R11",
          "finish state", {done, busy, bus_valid}, 3'b100);
    for (int e = 0; e < NE; e++)
      check(phy_reg[t_reg[e]] === exp_final[t_reg[e]], "R5", "merged register",
            phy_reg[t_reg[e]], exp_final[t_reg[e]]);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) phy_reg[i] = 8'(i * 37 + 5);
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && bus_valid === 1'b0, "R1",
          "state in reset", {busy, done, bus_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && bus_valid === 1'b0, "R1",
          "state after reset", {busy, done, bus_valid}, 0);

    // Pass A: no stalls (R2..R8)
    run_pass(1'b0, 1'b0);

    // Pass B: all-ones registers, random stalls (R10), start held through
    // the final handshake edge (R11)
    for (int i = 0; i < 32; i++) phy_reg[i] = 8'hFF;
    run_pass(1'b1, 1'b1);
    repeat (5) @(negedge clk);
    check(busy === 1'b0 && done === 1'b1 && bus_valid === 1'b0, "R11",
          "no restart from held start", {busy, done, bus_valid}, 3'b010);

    // Legacy: no bus traffic, done next cycle (R9)
    for (int i = 0; i < 32; i++) phy_reg[i] = 8'h00;
    legacy_mode = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1 && busy === 1'b0 && bus_valid === 1'b0, "R9",
          "legacy completion", {done, busy, bus_valid}, 3'b100);
    repeat (10) @(negedge clk);
    check(phy_reg[7] === 8'h00 && phy_reg[28] === 8'h00, "R9",
          "registers untouched", {phy_reg[7], phy_reg[28]}, 0);
    legacy_mode = 1'b0;

    // Pass C: all-zero registers with stalls (R8 ordering again)
    run_pass(1'b1, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule